// File: doc/BRIEF.md
# Indexed Colour Lookup Table with Sequential Loader

This block converts 8-bit pixel indices into 24-bit RGB words through a 256-entry lookup table. A host fills the table through a write-only register port with two offsets: a pointer register that selects the entry to load, and a colour-data register. Successive bytes written to the colour-data register go into the red, green and blue components of the selected entry, in that order. After the blue byte the pointer moves on to the next entry by itself, so a whole table can be streamed in after a single pointer write.

A host write carries a width qualifier. A narrow write delivers one byte. A wide write delivers four bytes, taken most significant byte first. The block spends four consecutive clocks on a wide write and raises a busy flag while it does so. A separate pixel port accepts an index on every clock and returns the matching RGB word one clock later. A one-cycle change pulse follows each accepted colour-data write, so that a display pipeline can schedule a full redraw.

After reset the block clears every entry by sweeping the table, with busy held high.

Top module: `palette_lut`

## Requirements
- R1: `pix_rgb` shows the entry selected by `pix_idx` at the previous rising clock edge, with red in bits 23:16, green in 15:8 and blue in 7:0.
- R2: An accepted write to offset 0x0 loads `wr_data[7:0]` as the entry pointer and returns the component phase to red.
- R3: An accepted narrow write (`wr_wide`=0) to offset 0x4 stores `wr_data[7:0]` into the red, green or blue component of the pointed entry, according to the phase, and then advances the phase. After a blue store the phase returns to red and the pointer increments.
- R4: An accepted wide write (`wr_wide`=1) to offset 0x4 is applied as four byte stores on four consecutive clocks, in the order `wr_data[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. Each store advances the phase as in R3, and `busy` is high for the three clocks after acceptance.
- R5: Writes presented while `busy` is high have no effect, and neither do writes to any offset other than 0x0 and 0x4.
- R6: `pal_changed` is high for exactly the one cycle after each accepted colour-data write, whatever its width.
- R7: Reset sets the pointer to 0 and the phase to red. Then, for 256 clocks after reset is released, the block clears every entry to zero while `busy` is high and `pix_rgb` reads zero.
- R8: When a pixel lookup and a byte store hit the same entry on the same edge, the lookup returns the value held before the store.
- R9: The pointer wraps from 255 to 0 after a blue store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Byte offset of the host write |
| wr_wide | input | 1 | 1: four-byte write, 0: single-byte write |
| wr_data | input | 32 | Host write data |
| busy | output | 1 | Clear sweep or wide unpack in progress; writes are ignored |
| pal_changed | output | 1 | One-cycle pulse after an accepted colour-data write |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | RGB word for the index of the previous clock |

## Verification
The loader is driven with runs of narrow writes that cross entry boundaries, with pointer rewrites in the middle of an entry, and with a wide write whose four bytes all differ. These patterns separate a wrong component order, a missing phase reset and a byte order reversed within a wide word. Writes issued during the wide unpack and to an unused offset are followed by a plain store, so a leaked write shows up as a shifted component. A load at entry 255 exposes a missing pointer wrap, and a lookup issued on the same edge as a store to that entry separates old-value reads from new-value reads. A behavioural model holds its own table, pointer and phase, and is compared with `pix_rgb`, `busy` and `pal_changed` on every clock, including through the clear sweep.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int NUM_CH = 3;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_chan_ram.sv
module pal_chan_ram #(
  parameter int IDX_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  // read-first single-clock dual-port memory
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_loader.sv
module pal_loader
  import palette_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int CH_W      = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int OFS_INDEX = 0,
  parameter int OFS_CMAP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              clearing,
  output logic              changed,
  output logic [NUM_CH-1:0] ch_we,
  output logic [IDX_W-1:0]  ch_addr,
  output logic [CH_W-1:0]   ch_data
);
  localparam int BYTES = DATA_W / CH_W;
  localparam int CNT_W = $clog2(BYTES);
  localparam int SH_W  = DATA_W - CH_W;

  logic             clr_q;
  logic [IDX_W-1:0] clr_cnt;
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] rem_q;
  logic [SH_W-1:0]  shq;
  logic             chg_q;

  logic unpacking, accept, hit_idx, hit_map, byte_go;
  logic [CH_W-1:0] byte_val;

  assign clearing  = clr_q;
  assign unpacking = (rem_q != '0);
  assign busy      = clr_q | unpacking;
  assign accept    = wr_en & ~busy;
  assign hit_idx   = accept & (wr_addr == ADDR_W'(OFS_INDEX));
  assign hit_map   = accept & (wr_addr == ADDR_W'(OFS_CMAP));
  assign byte_go   = unpacking | hit_map;

  always_comb begin
    if (unpacking)    byte_val = shq[SH_W-1 -: CH_W];
    else if (wr_wide) byte_val = wr_data[DATA_W-1 -: CH_W];
    else              byte_val = wr_data[CH_W-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign ch_we[c] = clr_q | (byte_go & (phase_q == phase_e'(c)));
  end

  assign ch_addr = clr_q ? clr_cnt : idx_q;
  assign ch_data = clr_q ? '0 : byte_val;
  assign changed = chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q   <= 1'b1;
      clr_cnt <= '0;
      idx_q   <= '0;
      phase_q <= PH_RED;
      rem_q   <= '0;
      shq     <= '0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= hit_map;
      if (clr_q) begin
        clr_cnt <= clr_cnt + 1'b1;
        if (clr_cnt == '1) clr_q <= 1'b0;
      end else begin
        if (hit_idx) begin
          idx_q   <= wr_data[IDX_W-1:0];
          phase_q <= PH_RED;
        end
        if (byte_go) begin
          case (phase_q)
            PH_RED:  phase_q <= PH_GRN;
            PH_GRN:  phase_q <= PH_BLU;
            default: begin
              phase_q <= PH_RED;
              idx_q   <= idx_q + 1'b1;
            end
          endcase
        end
        if (unpacking) begin
          rem_q <= rem_q - 1'b1;
          shq   <= shq << CH_W;
        end else if (hit_map && wr_wide) begin
          rem_q <= CNT_W'(BYTES - 1);
          shq   <= wr_data[SH_W-1:0];
        end
      end
    end
  end

  a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase_q inside {PH_RED, PH_GRN, PH_BLU});

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (byte_go && phase_q == PH_BLU) |=> (idx_q == $past(idx_q) + 1'b1));

  a_r4_unpack_busy: assert property (@(posedge clk) disable iff (rst)
    (hit_map && wr_wide) |=> busy);

  a_r5_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> !changed);

  a_r6_change_pulse: assert property (@(posedge clk) disable iff (rst)
    hit_map |=> changed);
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int CH_W      = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int OFS_INDEX = 0,
  parameter int OFS_CMAP  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   wr_wide,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   busy,
  output logic                   pal_changed,
  input  logic [IDX_W-1:0]       pix_idx,
  output logic [NUM_CH*CH_W-1:0] pix_rgb
);
  localparam int RGB_W = NUM_CH * CH_W;

  logic              clearing;
  logic [NUM_CH-1:0] ch_we;
  logic [IDX_W-1:0]  ch_addr;
  logic [CH_W-1:0]   ch_data;
  logic [RGB_W-1:0]  raw_rgb;
  logic              pix_ok_q;

  pal_loader #(
    .IDX_W(IDX_W), .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .OFS_INDEX(OFS_INDEX), .OFS_CMAP(OFS_CMAP)
  ) u_loader (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
    .busy(busy), .clearing(clearing), .changed(pal_changed),
    .ch_we(ch_we), .ch_addr(ch_addr), .ch_data(ch_data)
  );

  // channel 0 (red) lands in the top byte
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pal_chan_ram #(.IDX_W(IDX_W), .DW(CH_W)) u_ram (
      .clk(clk), .we(ch_we[c]), .waddr(ch_addr), .wdata(ch_data),
      .raddr(pix_idx), .rdata(raw_rgb[(NUM_CH-1-c)*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pix_ok_q <= 1'b0;
    else     pix_ok_q <= ~clearing;
  end

  assign pix_rgb = pix_ok_q ? raw_rgb : '0;

  a_r7_clear_dark: assert property (@(posedge clk) disable iff (rst)
    clearing |=> (pix_rgb == '0));

  a_r7_clear_busy: assert property (@(posedge clk) disable iff (rst)
    clearing |-> busy);
endmodule

// File: tb/tb_palette_lut.sv
module tb_palette_lut;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic        wr_wide = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy, pal_changed;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int n_chk = 0, n_err = 0, cyc = 0;

  palette_lut dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide),
    .wr_data(wr_data), .busy(busy), .pal_changed(pal_changed),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  byte unsigned m_r[256], m_g[256], m_b[256];
  int   m_idx = 0, m_ph = 0, clr_left = 0, unp_left = 0;
  byte unsigned pend[$];
  logic [23:0] e_pix = '0;
  logic e_busy = 1'b0, e_chg = 1'b0;

  task automatic put_byte(input byte unsigned v);
    if (m_ph == 0) m_r[m_idx] = v;
    else if (m_ph == 1) m_g[m_idx] = v;
    else m_b[m_idx] = v;
    if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
    else m_ph = m_ph + 1;
  endtask

  always @(posedge clk) begin
    logic [23:0] nxt;
    logic mbusy;
    nxt = (clr_left > 0) ? 24'h0 : {m_r[pix_idx], m_g[pix_idx], m_b[pix_idx]};
    if (rst) begin
      clr_left = 256; unp_left = 0; m_idx = 0; m_ph = 0; pend.delete();
      e_chg = 1'b0; nxt = 24'h0;
    end else begin
      mbusy = (clr_left > 0) || (unp_left > 0);
      e_chg = wr_en && !mbusy && wr_addr == 5'd4;
      if (clr_left > 0) begin
        m_r[256-clr_left] = 0; m_g[256-clr_left] = 0; m_b[256-clr_left] = 0;
        clr_left = clr_left - 1;
      end else if (unp_left > 0) begin
        put_byte(pend.pop_front());
        unp_left = unp_left - 1;
      end else if (wr_en) begin
        if (wr_addr == 5'd0) begin m_idx = int'(wr_data[7:0]); m_ph = 0; end
        else if (wr_addr == 5'd4) begin
          if (wr_wide) begin
            put_byte(wr_data[31:24]);
            pend.push_back(wr_data[23:16]);
            pend.push_back(wr_data[15:8]);
            pend.push_back(wr_data[7:0]);
            unp_left = 3;
          end else put_byte(wr_data[7:0]);
        end
      end
    end
    e_pix  = nxt;
    e_busy = (clr_left > 0) || (unp_left > 0);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk("R1 pix_rgb vs model", {8'h0, pix_rgb}, {8'h0, e_pix});
      chk("R4 busy vs model", {31'h0, busy}, {31'h0, e_busy});
      chk("R6 pal_changed vs model", {31'h0, pal_changed}, {31'h0, e_chg});
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog act=hung exp=done");
      summary();
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic w);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_wide = w;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic look(input logic [7:0] i, input logic [23:0] exp, input string tag);
    pix_idx = i;
    @(negedge clk);
    chk(tag, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    chk("R7 busy in reset", {31'h0, busy}, 32'h1);
    rst = 1'b0;
    nb = 0;
    while (busy) begin nb++; @(negedge clk); end
    chk("R7 clear sweep length", nb, 256);
    look(8'd0, 24'h0, "R7 entry 0 cleared");
    look(8'd255, 24'h0, "R7 entry 255 cleared");

    // R3 narrow stores in rotation, crossing an entry
    wr(5'd0, 32'd5, 1'b0);
    wr(5'd4, 32'h11, 1'b0); wr(5'd4, 32'h22, 1'b0);
    wr(5'd4, 32'h33, 1'b0); wr(5'd4, 32'h44, 1'b0);
    look(8'd5, 24'h112233, "R3 entry 5 rgb");
    look(8'd6, 24'h440000, "R3 pointer advanced to 6");

    // R2 pointer rewrite resets phase to red
    wr(5'd0, 32'd5, 1'b0);
    wr(5'd4, 32'hAA, 1'b0);
    look(8'd5, 24'hAA2233, "R2 phase reset to red");

    // R4 wide store, MSB first; R5 writes during busy and to unused offset
    wr(5'd0, 32'd10, 1'b0);
    wr(5'd4, 32'h01020304, 1'b1);
    chk("R6 pulse after wide", {31'h0, pal_changed}, 32'h1);
    chk("R4 busy after wide", {31'h0, busy}, 32'h1);
    wr(5'd4, 32'hEE, 1'b0);
    chk("R6 single pulse per wide", {31'h0, pal_changed}, 32'h0);
    wait_idle();
    wr(5'd4, 32'h55, 1'b0);
    wr(5'd8, 32'h77, 1'b0);
    wr(5'd4, 32'h66, 1'b0);
    look(8'd10, 24'h010203, "R4 wide bytes order");
    look(8'd11, 24'h045566, "R5 busy and unused offset ignored");

    // R9 wrap at 255
    wr(5'd0, 32'd255, 1'b0);
    wr(5'd4, 32'h01, 1'b0); wr(5'd4, 32'h02, 1'b0);
    wr(5'd4, 32'h03, 1'b0); wr(5'd4, 32'h09, 1'b0);
    look(8'd255, 24'h010203, "R9 entry 255");
    look(8'd0, 24'h090000, "R9 pointer wrapped to 0");

    // R8 lookup and store on the same edge
    wr(5'd0, 32'd20, 1'b0);
    pix_idx = 8'd20;
    wr(5'd4, 32'h5A, 1'b0);
    chk("R8 old value on same edge", {8'h0, pix_rgb}, 32'h0);
    @(negedge clk);
    chk("R8 new value next edge", {8'h0, pix_rgb}, 32'h5A0000);

    // R1 a run of lookups against the model
    for (int i = 0; i < 24; i++) begin
      pix_idx = 8'(i);
      @(negedge clk);
    end
    look(8'd5, 24'hAA2233, "R1 field placement");

    // R7 reset mid-run clears the table again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    wait_idle();
    look(8'd5, 24'h0, "R7 entry cleared after second reset");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule